// File: doc/BRIEF.md
# ADC Offset Calibration Sequencer

This block measures, stores and applies DC offset corrections for three conversion paths: the receive I path, the receive Q path and an auxiliary path. Every auxiliary input shares one correction value. Software starts a measurement by writing a request mask over a small register bus. The block then runs one converter request per selected path through a shared converter handshake. It saturates each returned result into a 9-bit signed correction and stores it. Software can also read or overwrite the stored corrections directly, with no measurement.

Live samples on each path pass through a subtractor that removes that path's correction. The result saturates to the sample width and appears one clock after the input. A converter measurement can take many thousands of cycles. The sequencer holds its request for as long as the converter needs and serves queued paths one at a time.

The sequencer is a three-state machine:
- `ST_IDLE` takes the transition *launch* to `ST_WAIT` when any request is pending. It picks the lowest-numbered pending path.
- `ST_WAIT` drives the converter request and takes *capture* to `ST_STORE` when the converter signals done. On capture it latches the saturated result.
- `ST_STORE` writes the correction, clears that path's request and takes *retire* back to `ST_IDLE`.

Top module: `ofs_cal_top`

## Requirements
- R1: After reset, all three corrections read 0, the control word reads 0, `conv_req` is low and all corrected-sample valids are low.
- R2: Address 1, 2 and 3 hold the I, Q and auxiliary corrections. A write stores `reg_wdata[8:0]` as a two's-complement value and ignores the bits above. A read returns the value sign-extended to 16 bits.
- R3: A write to address 0 adds request bits `reg_wdata[0]` (I), `[1]` (Q) and `[2]` (auxiliary) to the pending set. The value 7 requests all three paths. Zero bits have no effect, and a write of 0 starts nothing.
- R4: A measurement raises `conv_req` with `conv_sel` = 0 (I), 1 (Q) or 2 (auxiliary). `conv_req` and `conv_sel` stay steady until the cycle in which `conv_done` is high.
- R5: The result sampled with `conv_done` is clamped to the range −256..+255 and stored as that path's correction.
- R6: Pending paths are measured one at a time in the order I, Q, auxiliary.
- R7: A read of address 0 returns the pending mask in bits [2:0] and a busy flag in bit 3. Each pending bit clears when its measurement is stored. Busy is high while any request is pending or a measurement is in progress.
- R8: A direct write to a path's correction during that path's measurement is replaced by the measured result. If both land in the same cycle, the measured result wins.
- R9: On each path, the corrected output equals the input sample minus the correction, saturated to the signed sample width. Its valid follows the input valid one clock later, and the data holds while the input is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 I, 2 Q, 3 auxiliary) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| conv_req | output | 1 | Converter measurement request |
| conv_sel | output | 2 | Path being measured |
| conv_done | input | 1 | Converter result valid, one cycle |
| conv_result | input | 12 | Signed converter result |
| i_in_valid | input | 1 | I sample valid |
| i_in_data | input | 12 | I sample, signed |
| q_in_valid | input | 1 | Q sample valid |
| q_in_data | input | 12 | Q sample, signed |
| aux_in_valid | input | 1 | Auxiliary sample valid |
| aux_in_data | input | 12 | Auxiliary sample, signed |
| i_out_valid | output | 1 | Corrected I valid |
| i_out_data | output | 12 | Corrected I sample |
| q_out_valid | output | 1 | Corrected Q valid |
| q_out_data | output | 12 | Corrected Q sample |
| aux_out_valid | output | 1 | Corrected auxiliary valid |
| aux_out_data | output | 12 | Corrected auxiliary sample |

## Verification
The assertions assume the converter behaves as a well-mannered partner:
- It raises `conv_done` only while `conv_req` is high.
- It raises `conv_done` for one cycle per request.
- It never signals done again before the request has dropped.

The bench's converter model keeps to this by counting a fixed delay after it sees the request, pulsing done once and then waiting for the request to fall. Register writes arrive on falling edges as single-cycle strobes. Samples change only between rising edges.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;
    localparam int NCH    = 3;
    localparam int CH_W   = 2;
    localparam int CH_I   = 0;
    localparam int CH_Q   = 1;
    localparam int CH_AUX = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_STORE = 2'd2
    } cal_state_t;

    typedef enum logic [1:0] {
        RA_CTRL    = 2'd0,
        RA_OFS_I   = 2'd1,
        RA_OFS_Q   = 2'd2,
        RA_OFS_AUX = 2'd3
    } reg_addr_t;
endpackage

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
    import ofs_cal_pkg::*;
#(
    parameter int OFS_W = 9,
    parameter int RES_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_we,
    input  logic [NCH-1:0]    trig_bits,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic [NCH-1:0]    pending,
    output logic              busy,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_sel,
    output logic              store_en,
    output logic [CH_W-1:0]   store_ch,
    output logic [OFS_W-1:0]  store_val
);
    localparam int MAX_OFS = 2**(OFS_W-1) - 1;
    localparam int MIN_OFS = -(2**(OFS_W-1));
    localparam logic [OFS_W-1:0] MAX_CODE = MAX_OFS[OFS_W-1:0];
    localparam logic [OFS_W-1:0] MIN_CODE = MIN_OFS[OFS_W-1:0];

    cal_state_t       state, state_n;
    logic [CH_W-1:0]  cur;
    logic [CH_W-1:0]  pick;
    logic [OFS_W-1:0] res_q;
    logic [OFS_W-1:0] res_sat;
    logic [NCH-1:0]   pend_n;

    // lowest-numbered pending path wins
    always_comb begin
        pick = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (pending[c]) pick = CH_W'(c);
        end
    end

    always_comb begin
        if ($signed(conv_result) > MAX_OFS)      res_sat = MAX_CODE;
        else if ($signed(conv_result) < MIN_OFS) res_sat = MIN_CODE;
        else                                     res_sat = conv_result[OFS_W-1:0];
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (|pending) state_n = ST_WAIT;
            ST_WAIT:  if (conv_done) state_n = ST_STORE;
            ST_STORE: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        pend_n = pending;
        if (state == ST_STORE) pend_n[cur] = 1'b0;
        if (trig_we) pend_n = pend_n | trig_bits;
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur     <= '0;
            res_q   <= '0;
            pending <= '0;
        end else begin
            state   <= state_n;
            pending <= pend_n;
            if (state == ST_IDLE && |pending) cur <= pick;
            if (state == ST_WAIT && conv_done) res_q <= res_sat;
        end
    end

    // outputs
    always_comb begin
        conv_req  = (state == ST_WAIT);
        conv_sel  = cur;
        store_en  = (state == ST_STORE);
        store_ch  = cur;
        store_val = res_q;
        busy      = (|pending) || (state != ST_IDLE);
    end

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_sel)));

    a_r6_q_after_i: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_req) && conv_sel != 2'd0) |-> !pending[0]);

    a_r6_aux_after_q: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_req) && conv_sel == 2'd2) |-> !pending[1]);

    a_r7_busy_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);

    a_r7_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        store_en |=> (!pending[cur] || $past(trig_we)));
endmodule

// File: rtl/ofs_corr.sv
module ofs_corr #(
    parameter int SAMP_W = 12,
    parameter int OFS_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_data,
    input  logic [OFS_W-1:0]  ofs,
    output logic              out_valid,
    output logic [SAMP_W-1:0] out_data
);
    localparam int DW   = SAMP_W + 2;
    localparam int SMAX = 2**(SAMP_W-1) - 1;
    localparam int SMIN = -(2**(SAMP_W-1));
    localparam logic [SAMP_W-1:0] SMAX_CODE = SMAX[SAMP_W-1:0];
    localparam logic [SAMP_W-1:0] SMIN_CODE = SMIN[SAMP_W-1:0];

    logic signed [DW-1:0] diff;
    logic [SAMP_W-1:0]    sat;

    always_comb begin
        diff = DW'($signed(in_data)) - DW'($signed(ofs));
        if (diff > SMAX)      sat = SMAX_CODE;
        else if (diff < SMIN) sat = SMIN_CODE;
        else                  sat = diff[SAMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= sat;
        end
    end

    a_r9_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_lag: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: rtl/ofs_cal_top.sv
module ofs_cal_top
    import ofs_cal_pkg::*;
#(
    parameter int SAMP_W = 12,
    parameter int OFS_W  = 9,
    parameter int RES_W  = 12,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              conv_req,
    output logic [1:0]        conv_sel,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              i_in_valid,
    input  logic [SAMP_W-1:0] i_in_data,
    input  logic              q_in_valid,
    input  logic [SAMP_W-1:0] q_in_data,
    input  logic              aux_in_valid,
    input  logic [SAMP_W-1:0] aux_in_data,
    output logic              i_out_valid,
    output logic [SAMP_W-1:0] i_out_data,
    output logic              q_out_valid,
    output logic [SAMP_W-1:0] q_out_data,
    output logic              aux_out_valid,
    output logic [SAMP_W-1:0] aux_out_data
);
    logic [NCH-1:0]    pending;
    logic              busy;
    logic              store_en;
    logic [CH_W-1:0]   store_ch;
    logic [OFS_W-1:0]  store_val;
    logic [OFS_W-1:0]  ofs_q [NCH];
    logic              in_v  [NCH];
    logic [SAMP_W-1:0] in_d  [NCH];
    logic              out_v [NCH];
    logic [SAMP_W-1:0] out_d [NCH];
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DW-1:OFS_W];

    ofs_cal_seq #(.OFS_W(OFS_W), .RES_W(RES_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_we    (reg_we && reg_addr == RA_CTRL),
        .trig_bits  (reg_wdata[NCH-1:0]),
        .conv_done  (conv_done),
        .conv_result(conv_result),
        .pending    (pending),
        .busy       (busy),
        .conv_req   (conv_req),
        .conv_sel   (conv_sel),
        .store_en   (store_en),
        .store_ch   (store_ch),
        .store_val  (store_val)
    );

    assign in_v[CH_I]   = i_in_valid;
    assign in_d[CH_I]   = i_in_data;
    assign in_v[CH_Q]   = q_in_valid;
    assign in_d[CH_Q]   = q_in_data;
    assign in_v[CH_AUX] = aux_in_valid;
    assign in_d[CH_AUX] = aux_in_data;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_path
            // a measured result takes priority over a bus write
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ofs_q[c] <= '0;
                else if (store_en && store_ch == CH_W'(c))
                    ofs_q[c] <= store_val;
                else if (reg_we && reg_addr == 2'(c + 1))
                    ofs_q[c] <= reg_wdata[OFS_W-1:0];
            end

            ofs_corr #(.SAMP_W(SAMP_W), .OFS_W(OFS_W)) u_corr (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_valid (in_v[c]),
                .in_data  (in_d[c]),
                .ofs      (ofs_q[c]),
                .out_valid(out_v[c]),
                .out_data (out_d[c])
            );

            a_r8_store_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (store_en && store_ch == CH_W'(c)) |=> (ofs_q[c] == $past(store_val)));
        end
    endgenerate

    assign i_out_valid   = out_v[CH_I];
    assign i_out_data    = out_d[CH_I];
    assign q_out_valid   = out_v[CH_Q];
    assign q_out_data    = out_d[CH_Q];
    assign aux_out_valid = out_v[CH_AUX];
    assign aux_out_data  = out_d[CH_AUX];

    always_comb begin
        unique case (reg_addr)
            RA_CTRL:    reg_rdata = {{(DW-NCH-1){1'b0}}, busy, pending};
            RA_OFS_I:   reg_rdata = {{(DW-OFS_W){ofs_q[CH_I][OFS_W-1]}}, ofs_q[CH_I]};
            RA_OFS_Q:   reg_rdata = {{(DW-OFS_W){ofs_q[CH_Q][OFS_W-1]}}, ofs_q[CH_Q]};
            RA_OFS_AUX: reg_rdata = {{(DW-OFS_W){ofs_q[CH_AUX][OFS_W-1]}}, ofs_q[CH_AUX]};
            default:    reg_rdata = '0;
        endcase
    end

    a_r4_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (conv_sel < 2'd3));

    a_r7_busy_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && reg_addr == RA_CTRL) |-> reg_rdata[3]);
endmodule

// File: tb/ofs_cal_top_test.sv
`timescale 1ns/1ps
module ofs_cal_top_test;
    localparam int SW = 12;
    localparam int CONV_DLY = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic conv_req;
    logic [1:0] conv_sel;
    logic conv_done = 1'b0;
    logic [11:0] conv_result = 12'd0;
    logic iv = 1'b0, qv = 1'b0, av = 1'b0;
    logic [SW-1:0] id = '0, qd = '0, ad = '0;
    logic iov, qov, aov;
    logic [SW-1:0] iod, qod, aod;

    int checks = 0;
    int fails = 0;
    int model_val [3];
    int log_sel [16];
    int log_n = 0;
    int cnt = 0;

    always #5 clk = ~clk;

    ofs_cal_top uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_req(conv_req),
        .conv_sel(conv_sel), .conv_done(conv_done), .conv_result(conv_result),
        .i_in_valid(iv), .i_in_data(id), .q_in_valid(qv), .q_in_data(qd),
        .aux_in_valid(av), .aux_in_data(ad),
        .i_out_valid(iov), .i_out_data(iod), .q_out_valid(qov), .q_out_data(qod),
        .aux_out_valid(aov), .aux_out_data(aod)
    );

    // converter model: fixed delay, one done pulse per request
    initial begin
        forever begin
            @(negedge clk);
            if (conv_done) begin
                conv_done = 1'b0;
            end else if (conv_req) begin
                if (cnt == CONV_DLY) begin
                    conv_done = 1'b1;
                    conv_result = 12'(model_val[conv_sel]);
                    if (log_n < 16) log_sel[log_n] = int'(conv_sel);
                    log_n++;
                    cnt = 0;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 2'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic wait_idle();
        int v;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            rd(0, v);
            if (v[3] == 1'b0) return;
        end
        chk("R7 busy never fell", 1, 0);
    endtask

    function automatic int sx9(input int v);
        return (v & 16'h100) != 0 ? ((v & 9'h1FF) | 16'hFE00) : (v & 9'h1FF);
    endfunction

    function automatic int clamp(input int v, input int lo, input int hi);
        return v > hi ? hi : (v < lo ? lo : v);
    endfunction

    initial begin
        #1_500_000;
        chk("watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int v;
        int ofs_list [6];
        int sat_list [12];
        model_val[0] = 0; model_val[1] = 0; model_val[2] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 conv_req low", int'(conv_req), 0);
        chk("R1 out valids low", int'(iov) + int'(qov) + int'(aov), 0);

        // R2 register sweep over all 9-bit codes, with junk above bit 8
        for (int c = 1; c < 4; c++) begin
            for (int x = 0; x < 512; x++) begin
                wr(c, x | 16'hA400);
                rd(c, v);
                chk("R2 offset readback", v, sx9(x));
            end
        end

        // R3 zero write starts nothing
        wr(0, 0);
        rd(0, v);
        chk("R3 zero trigger idle", v, 0);

        // R3 R6 R5 full request with 7
        model_val[0] = 100; model_val[1] = -300; model_val[2] = 255;
        log_n = 0;
        wr(0, 7);
        rd(0, v);
        chk("R7 status after trigger", v, 16'h000F);
        wait_idle();
        chk("R6 measurement count", log_n, 3);
        chk("R6 first is I", log_sel[0], 0);
        chk("R6 second is Q", log_sel[1], 1);
        chk("R6 third is aux", log_sel[2], 2);
        rd(1, v); chk("R5 I stored", v, 100);
        rd(2, v); chk("R5 Q clamped", v, 16'hFF00);
        rd(3, v); chk("R5 aux stored", v, 255);
        rd(0, v); chk("R7 pending cleared", v, 0);

        // R3 single bit: only Q measured, I untouched
        model_val[0] = 5; model_val[1] = -7;
        log_n = 0;
        wr(0, 2);
        wait_idle();
        chk("R3 only one measurement", log_n, 1);
        chk("R4 selected Q", log_sel[0], 1);
        rd(1, v); chk("R3 I unchanged", v, 100);
        rd(2, v); chk("R3 Q measured", v, 16'hFFF9);

        // R7 mask 5 and order I then aux
        log_n = 0;
        model_val[0] = -1; model_val[2] = 3;
        wr(0, 5);
        rd(0, v);
        chk("R7 status mask 5", v, 16'h000D);
        wait_idle();
        chk("R6 order I first", log_sel[0], 0);
        chk("R6 order aux next", log_sel[1], 2);

        // R5 saturation sweep on the auxiliary path
        sat_list = '{-2048, -1000, -257, -256, -255, -1, 0, 1, 254, 255, 256, 2047};
        for (int k = 0; k < 12; k++) begin
            model_val[2] = sat_list[k];
            wr(0, 4);
            wait_idle();
            rd(3, v);
            chk("R5 saturated result", v, clamp(sat_list[k], -256, 255) & 16'hFFFF);
        end

        // R8 direct write during that path's measurement
        model_val[1] = 77;
        wr(0, 2);
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (conv_req && conv_sel == 2'd1) break;
        end
        chk("R4 request raised for Q", int'(conv_req), 1);
        wr(2, 5);
        rd(2, v);
        chk("R8 write visible mid measurement", v, 5);
        wait_idle();
        rd(2, v);
        chk("R8 result overrides write", v, 77);

        // R9 correction sweep over every sample on all three paths
        ofs_list = '{-256, -1, 0, 1, 255, 100};
        for (int k = 0; k < 6; k++) begin
            int o;
            o = ofs_list[k];
            wr(1, o); wr(2, -o - 1); wr(3, o / 2);
            for (int s = -2048; s < 2048; s++) begin
                @(negedge clk);
                iv = 1'b1; qv = 1'b1; av = 1'b1;
                id = SW'(s); qd = SW'(s); ad = SW'(s);
                @(negedge clk);
                iv = 1'b0; qv = 1'b0; av = 1'b0;
                chk("R9 I valid", int'(iov), 1);
                chk("R9 I data", int'($signed(iod)), clamp(s - o, -2048, 2047));
                chk("R9 Q data", int'($signed(qod)), clamp(s + o + 1, -2048, 2047));
                chk("R9 aux data", int'($signed(aod)), clamp(s - o / 2, -2048, 2047));
            end
        end
        // R9 invalid input: no valid, data held
        @(negedge clk);
        id = 12'h123;
        @(negedge clk);
        chk("R9 valid drops", int'(iov), 0);
        chk("R9 data held", int'($signed(iod)), clamp(2047 - 100, -2048, 2047));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule